// File: doc/BRIEF.md
# Line-Synchronous Gate Pulse Generator

This block runs on the four-times-subcarrier sample clock, where one tick lasts about 70 ns. It builds the per-line timing gates that a video front end needs, and all of them are measured from a horizontal sync edge that the block has accepted. A single tick counter restarts on each accepted edge. Three things are decoded from that counter:

- a burst gate, whose start position is programmable;
- a back-porch clamp gate, whose start is adjusted separately;
- a noise-mask window. While the window is open, any further sync strobe is treated as noise and dropped.

A raw sync strobe comes in together with three configuration fields. The block drives out a qualified line-start pulse and the three gate levels. If no strobe is accepted for a full line-timeout period, the counter restarts on its own, so the gates keep running while sync is missing. The configuration fields are captured only when a line starts. A gate that is already in progress is therefore never cut short or stretched by a register write.

Top module: `sync_gate_gen`

## Requirements
- R1: While reset is high, and after reset until the first line start, `line_start`, `burst_gate`, `clamp_gate` and `mask_win` are all 0.
- R2: A high `hsync_edge` sampled while `mask_win` is 0 is accepted, and `line_start` is high for the next clock cycle. That cycle is tick 0 of the new line, and each later cycle adds one tick.
- R3: `burst_gate` is high exactly for ticks 53+P through 53+P+42, a width of 43 ticks, where P is the 6-bit `burst_phase` captured at the line start.
- R4: `clamp_gate` is high exactly for ticks 80+C through 80+C+36, a width of 37 ticks, where C is the 4-bit `clamp_adj` captured at the line start.
- R5: `mask_win` is high for ticks 0 up to L-1 of a line, with L taken from the captured `mask_sel`: code 0 gives 687, code 1 gives 630 and code 2 gives 759. A strobe sampled inside the window produces no `line_start` and does not restart the line.
- R6: When the captured `mask_sel` is 3, `mask_win` stays 0 and every strobe is accepted, whatever tick it arrives on.
- R7: If no strobe is accepted by tick 999, the next cycle is a self-generated line start. With sync absent, `line_start` therefore pulses once every 1000 ticks.
- R8: `burst_phase`, `clamp_adj` and `mask_sel` are captured only when a line starts. A change in the middle of a line has no effect on the gates until the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| hsync_edge | input | 1 | Raw horizontal sync leading-edge strobe |
| burst_phase | input | 6 | Burst gate start offset in ticks |
| clamp_adj | input | 4 | Clamp gate start offset in ticks |
| mask_sel | input | 2 | Noise-mask length select (0: 687, 1: 630, 2: 759 ticks, 3: off) |
| line_start | output | 1 | One-cycle pulse at tick 0 of each line |
| burst_gate | output | 1 | Burst gate level |
| clamp_gate | output | 1 | Back-porch clamp gate level |
| mask_win | output | 1 | High while sync strobes are being rejected |

## Verification
A cycle-by-cycle reference model is compared against the outputs while the strobe pattern changes. The patterns are:

- **A strobe one tick early and then one tick on time against the 630-tick mask.** This separates the correct window length from an off-by-one error.
- **A strobe at an arbitrary tick with masking disabled.** This shows that the mask-off code really bypasses the window.
- **A long stretch with no strobe at all.** This exposes the free-running period.
- **A phase write in the middle of a line.** Probing the gate one tick before and one tick after the expected edge shows whether the old captured value or the new one governs the current line.

// File: rtl/sgg_pkg.sv
package sgg_pkg;

    typedef enum logic [1:0] {
        MASK_LONG  = 2'd0,
        MASK_SHORT = 2'd1,
        MASK_XLONG = 2'd2,
        MASK_OFF   = 2'd3
    } mask_sel_e;

    typedef struct packed {
        logic [5:0] phase;
        logic [3:0] clamp;
        mask_sel_e  msel;
    } gate_cfg_t;

    localparam int DEF_LINE_LIMIT = 1000;
    localparam int DEF_BURST_BASE = 53;
    localparam int DEF_BURST_W    = 43;
    localparam int DEF_CLAMP_BASE = 80;
    localparam int DEF_CLAMP_W    = 37;
    localparam int DEF_MASK_LONG  = 687;
    localparam int DEF_MASK_SHORT = 630;
    localparam int DEF_MASK_XLONG = 759;

    function automatic int mask_ticks(input mask_sel_e sel, input int t_long,
                                      input int t_short, input int t_xlong);
        case (sel)
            MASK_LONG:  return t_long;
            MASK_SHORT: return t_short;
            MASK_XLONG: return t_xlong;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/sgg_line_ctrl.sv
module sgg_line_ctrl
    import sgg_pkg::*;
#(
    parameter int LINE_LIMIT = DEF_LINE_LIMIT,
    parameter int MASK_LONG_T  = DEF_MASK_LONG,
    parameter int MASK_SHORT_T = DEF_MASK_SHORT,
    parameter int MASK_XLONG_T = DEF_MASK_XLONG,
    parameter int CNT_W = $clog2(LINE_LIMIT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_edge,
    input  gate_cfg_t        cfg_in,
    output logic [CNT_W-1:0] pos,
    output logic             seen,
    output gate_cfg_t        cfg_q,
    output logic             line_start,
    output logic             mask_win
);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(LINE_LIMIT - 1);

    logic [CNT_W-1:0] win_len;
    logic             accept;
    logic             restart;

    always_comb begin
        win_len  = CNT_W'(mask_ticks(cfg_q.msel, MASK_LONG_T, MASK_SHORT_T, MASK_XLONG_T));
        mask_win = seen && (cfg_q.msel != MASK_OFF) && (pos < win_len);
        accept   = hsync_edge && !mask_win;
        restart  = accept || (pos == LAST_TICK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos        <= '0;
            seen       <= 1'b0;
            cfg_q      <= '0;
            line_start <= 1'b0;
        end else if (restart) begin
            pos        <= '0;
            seen       <= 1'b1;
            cfg_q      <= cfg_in;
            line_start <= 1'b1;
        end else begin
            pos        <= pos + 1'b1;
            line_start <= 1'b0;
        end
    end

endmodule

// File: rtl/sgg_gate_window.sv
module sgg_gate_window #(
    parameter int CNT_W = 10,
    parameter int WIDTH = 8
) (
    input  logic             enable,
    input  logic [CNT_W-1:0] pos,
    input  logic [CNT_W-1:0] start,
    output logic             gate
);
    logic [CNT_W-1:0] stop;

    always_comb begin
        stop = start + CNT_W'(WIDTH);
        gate = enable && (pos >= start) && (pos < stop);
    end

endmodule

// File: rtl/sync_gate_gen.sv
module sync_gate_gen
    import sgg_pkg::*;
#(
    parameter int LINE_LIMIT   = DEF_LINE_LIMIT,
    parameter int BURST_BASE   = DEF_BURST_BASE,
    parameter int BURST_W      = DEF_BURST_W,
    parameter int CLAMP_BASE   = DEF_CLAMP_BASE,
    parameter int CLAMP_W      = DEF_CLAMP_W,
    parameter int MASK_LONG_T  = DEF_MASK_LONG,
    parameter int MASK_SHORT_T = DEF_MASK_SHORT,
    parameter int MASK_XLONG_T = DEF_MASK_XLONG
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hsync_edge,
    input  logic [5:0] burst_phase,
    input  logic [3:0] clamp_adj,
    input  logic [1:0] mask_sel,
    output logic       line_start,
    output logic       burst_gate,
    output logic       clamp_gate,
    output logic       mask_win
);
    localparam int CNT_W = $clog2(LINE_LIMIT);

    gate_cfg_t        cfg_in;
    gate_cfg_t        cfg_q;
    logic [CNT_W-1:0] pos;
    logic             seen;
    logic [CNT_W-1:0] burst_start;
    logic [CNT_W-1:0] clamp_start;

    always_comb begin
        cfg_in.phase = burst_phase;
        cfg_in.clamp = clamp_adj;
        cfg_in.msel  = mask_sel_e'(mask_sel);
        burst_start  = CNT_W'(BURST_BASE) + CNT_W'(cfg_q.phase);
        clamp_start  = CNT_W'(CLAMP_BASE) + CNT_W'(cfg_q.clamp);
    end

    sgg_line_ctrl #(
        .LINE_LIMIT  (LINE_LIMIT),
        .MASK_LONG_T (MASK_LONG_T),
        .MASK_SHORT_T(MASK_SHORT_T),
        .MASK_XLONG_T(MASK_XLONG_T),
        .CNT_W       (CNT_W)
    ) line_i (
        .clk       (clk),
        .rst       (rst),
        .hsync_edge(hsync_edge),
        .cfg_in    (cfg_in),
        .pos       (pos),
        .seen      (seen),
        .cfg_q     (cfg_q),
        .line_start(line_start),
        .mask_win  (mask_win)
    );

    sgg_gate_window #(.CNT_W(CNT_W), .WIDTH(BURST_W)) burst_i (
        .enable(seen),
        .pos   (pos),
        .start (burst_start),
        .gate  (burst_gate)
    );

    sgg_gate_window #(.CNT_W(CNT_W), .WIDTH(CLAMP_W)) clamp_i (
        .enable(seen),
        .pos   (pos),
        .start (clamp_start),
        .gate  (clamp_gate)
    );

endmodule

// File: rtl/sync_gate_gen_chk.sv
module sync_gate_gen_chk #(
    parameter int LINE_LIMIT = 1000,
    parameter int BURST_BASE = 53,
    parameter int BURST_W    = 43,
    parameter int CLAMP_BASE = 80,
    parameter int CLAMP_W    = 37
) (
    input logic clk,
    input logic rst,
    input logic hsync_edge,
    input logic line_start,
    input logic burst_gate,
    input logic clamp_gate,
    input logic mask_win
);
    localparam int PW = $clog2(LINE_LIMIT) + 1;

    logic [PW-1:0] tick_c;
    logic [PW-1:0] here;
    logic          seen_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_c <= '0;
            seen_c <= 1'b0;
        end else begin
            if (line_start) seen_c <= 1'b1;
            if (line_start) tick_c <= PW'(1);
            else if (tick_c < PW'(LINE_LIMIT)) tick_c <= tick_c + 1'b1;
        end
    end

    assign here = line_start ? '0 : tick_c;

    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (!seen_c && !line_start) |-> (!burst_gate && !clamp_gate && !mask_win));

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (hsync_edge && !mask_win) |=> line_start);

    p_burst_span_r3: assert property (@(posedge clk) disable iff (rst)
        burst_gate |-> (here >= PW'(BURST_BASE) && here < PW'(BURST_BASE + 63 + BURST_W)));

    p_clamp_span_r4: assert property (@(posedge clk) disable iff (rst)
        clamp_gate |-> (here >= PW'(CLAMP_BASE) && here < PW'(CLAMP_BASE + 15 + CLAMP_W)));

    p_reject_r5: assert property (@(posedge clk) disable iff (rst)
        (hsync_edge && mask_win && here != PW'(LINE_LIMIT - 1)) |=> !line_start);

    p_freerun_r7: assert property (@(posedge clk) disable iff (rst)
        !line_start |-> (tick_c < PW'(LINE_LIMIT)));

endmodule

bind sync_gate_gen sync_gate_gen_chk #(
    .LINE_LIMIT(LINE_LIMIT),
    .BURST_BASE(BURST_BASE),
    .BURST_W   (BURST_W),
    .CLAMP_BASE(CLAMP_BASE),
    .CLAMP_W   (CLAMP_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .hsync_edge(hsync_edge),
    .line_start(line_start),
    .burst_gate(burst_gate),
    .clamp_gate(clamp_gate),
    .mask_win  (mask_win)
);

// File: tb/sync_gate_gen_tb_top.sv
module sync_gate_gen_tb_top;
    localparam int CLK_PERIOD = 70;

    typedef struct packed {
        logic ls;
        logic burst;
        logic clamp;
        logic mask;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_edge = 1'b0;
    logic [5:0] burst_phase = 6'd14;
    logic [3:0] clamp_adj = 4'd4;
    logic [1:0] mask_sel = 2'd0;
    logic       line_start, burst_gate, clamp_gate, mask_win;

    int checks = 0;
    int errors = 0;
    exp_t exp_q[$];

    // reference state built from the requirements
    int       m_pos = 0;
    bit       m_seen = 0;
    int       m_ph = 0, m_cl = 0, m_sel = 0;
    int       ls_count = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_gate_gen dut_i (
        .clk(clk), .rst(rst), .hsync_edge(hsync_edge),
        .burst_phase(burst_phase), .clamp_adj(clamp_adj), .mask_sel(mask_sel),
        .line_start(line_start), .burst_gate(burst_gate),
        .clamp_gate(clamp_gate), .mask_win(mask_win)
    );

    function automatic int win_of(int s);
        return (s == 0) ? 687 : (s == 1) ? 630 : (s == 2) ? 759 : 0;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // driver side of the scoreboard: predict outputs for every cycle
    always @(posedge clk) begin
        exp_t e;
        bit   open, ls;
        ls = 0;
        if (rst) begin
            m_pos = 0; m_seen = 0; m_ph = 0; m_cl = 0; m_sel = 0;
        end else begin
            open = m_seen && m_sel != 3 && m_pos < win_of(m_sel);
            if ((hsync_edge && !open) || m_pos == 999) begin
                m_pos = 0; m_seen = 1; ls = 1;
                m_ph = burst_phase; m_cl = clamp_adj; m_sel = mask_sel;
            end else begin
                m_pos = m_pos + 1;
            end
        end
        e.ls    = ls;
        e.burst = m_seen && m_pos >= 53 + m_ph && m_pos < 53 + m_ph + 43;
        e.clamp = m_seen && m_pos >= 80 + m_cl && m_pos < 80 + m_cl + 37;
        e.mask  = m_seen && m_sel != 3 && m_pos < win_of(m_sel);
        exp_q.push_back(e);
    end

    // monitor side: pop and compare away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(line_start == e.ls,    "R2 line_start", line_start, e.ls);
            check(burst_gate == e.burst, "R3 burst_gate", burst_gate, e.burst);
            check(clamp_gate == e.clamp, "R4 clamp_gate", clamp_gate, e.clamp);
            check(mask_win   == e.mask,  "R5 mask_win",   mask_win,   e.mask);
        end
        if (!rst && line_start) ls_count++;
    end

    task automatic wait_pos(int k);
        @(negedge clk);
        while (m_pos != k) @(negedge clk);
    endtask

    task automatic strobe(bit expect_ls, string tag);
        hsync_edge = 1'b1;
        @(negedge clk);
        hsync_edge = 1'b0;
        check(line_start == expect_ls, tag, line_start, expect_ls);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({line_start, burst_gate, clamp_gate, mask_win} == 4'b0, "R1 in reset",
              {line_start, burst_gate, clamp_gate, mask_win}, 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check({line_start, burst_gate, clamp_gate, mask_win} == 4'b0, "R1 before first line",
              {line_start, burst_gate, clamp_gate, mask_win}, 0);

        // R2: first strobe accepted; capture mask code 1 (630 ticks)
        mask_sel = 2'd1;
        strobe(1'b1, "R2 first strobe accepted");

        // R5: one tick early is rejected, on time is accepted
        wait_pos(629);
        strobe(1'b0, "R5 strobe at tick 629 rejected");
        check(m_pos == 630, "R5 line not restarted", m_pos, 630);
        strobe(1'b1, "R5 strobe at tick 630 accepted");

        // capture phase 10 and masking off
        burst_phase = 6'd10; mask_sel = 2'd3;
        wait_pos(700);
        strobe(1'b1, "R2 strobe after window accepted");

        // R8: mid-line phase change must not move this line's burst
        wait_pos(20);
        burst_phase = 6'd0;
        wait_pos(62);
        check(burst_gate == 1'b0, "R8 burst before old start", burst_gate, 0);
        @(negedge clk);
        check(burst_gate == 1'b1, "R8 burst at old start 63", burst_gate, 1);
        wait_pos(105);
        check(burst_gate == 1'b1, "R3 burst last tick", burst_gate, 1);
        @(negedge clk);
        check(burst_gate == 1'b0, "R3 burst ends after 43", burst_gate, 0);

        // R6: masking off accepts a strobe at any tick
        wait_pos(110);
        check(mask_win == 1'b0, "R6 window stays closed", mask_win, 0);
        strobe(1'b1, "R6 strobe at tick 110 accepted");

        // R3/R4 with phase 0 and clamp 4
        wait_pos(52);
        check(burst_gate == 1'b0, "R3 burst tick 52", burst_gate, 0);
        @(negedge clk);
        check(burst_gate == 1'b1, "R3 burst tick 53", burst_gate, 1);
        wait_pos(83);
        check(clamp_gate == 1'b0, "R4 clamp tick 83", clamp_gate, 0);
        @(negedge clk);
        check(clamp_gate == 1'b1, "R4 clamp tick 84", clamp_gate, 1);
        wait_pos(120);
        check(clamp_gate == 1'b1, "R4 clamp tick 120", clamp_gate, 1);
        @(negedge clk);
        check(clamp_gate == 1'b0, "R4 clamp tick 121", clamp_gate, 0);

        // capture mask code 0 (687 ticks), then probe its edge
        mask_sel = 2'd0; clamp_adj = 4'd15;
        wait_pos(300);
        strobe(1'b1, "R6 strobe captures new mask");
        wait_pos(686);
        check(mask_win == 1'b1, "R5 window open at 686", mask_win, 1);
        strobe(1'b0, "R5 strobe at tick 686 rejected");
        check(mask_win == 1'b0, "R5 window closed at 687", mask_win, 0);

        // R7: no strobes, self-timed lines every 1000 ticks
        wait_pos(0);
        ls_count = 0;
        repeat (2000) @(negedge clk);
        check(ls_count == 2, "R7 free-run line count", ls_count, 2);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule